// File: doc/BRIEF.md
# Guest Control-Register Write Unit

This block carries out one instruction: a move from a general register into a register of the guest-context system-control set. Each cycle it may receive an instruction word with a valid strobe. With the word come the 64-bit value of the source general register and two status flags: whether control-register access is enabled, and whether the virtualization feature is present. The block checks that the word is its instruction and raises at most one of two exceptions. When the write is legal, it shapes the source data and commits it on the next rising clock edge into a small register file that it holds.

The guest register set has eight slots, all set by parameters. Each slot has a selector key, a present flag, a read-only flag, an entry-low remap flag and a guest-writable mask. The two TLB entry-low slots get a bit remap so that a 32-bit value can carry the two top protection bits. The counter slot is read-only. The watch slot is shared, so only its guest-visible bits can change. A selector that matches no present slot is dropped without an exception. A separate read port lets a testbench see what each slot holds.

Top module: `gcr_write_unit`

## Requirements
- R1: The block accepts a word only when bits [31:26]=000000, [15:14]=00, [10:6]=11011 and [5:0]=111100. The source index sits in [25:21], rs in [20:16] and sel in [13:11]. Any other valid word raises `not_mine`, with no write and no exception.
- R2: A valid, matching word with `cp0_usable`=0 raises `exc_cpu` only. This holds whatever `vz_present` is. No write takes place.
- R3: A valid, matching word with `cp0_usable`=1 and `vz_present`=0 raises `exc_ri` only, and no write takes place.
- R4: A write to an entry-low slot stores source bit 31 in bit 63, source bit 30 in bit 62, zeros in bits 61:30, and source bits 29:0 in bits 29:0. The entry-low slots are key {rs=2,sel=0} at slot 0 and key {rs=3,sel=0} at slot 1.
- R5: A write to any other fully writable slot stores all 64 source bits unchanged. These slots are key {4,0} at slot 4, {5,0} at slot 5 and {4,2} at slot 6.
- R6: A key that matches no slot, or a slot whose present flag is 0 (key {22,0}, slot 7), gives no write and no exception.
- R7: The counter slot (key {9,0}, slot 2) is read-only. A write to it gives `wr_en`=0, raises no exception and leaves its value unchanged.
- R8: The shared slot (key {19,0}, slot 3) accepts writes, but only the bits in its guest mask 0xFF8 (bits 11:3) change. All its other bits keep their old values.
- R9: A write commits on the rising edge only when `in_valid`=1. With `in_valid`=0, all outputs except `rd_data` stay 0. A synchronous reset clears every slot to zero.
- R10: The destination slot is chosen by rs and sel together. A committed write drives `wr_en`=1, sets `wr_idx` to the slot number and `wr_data` to the value being stored, and the new value appears on the read port after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word valid this cycle |
| instr | input | 32 | Instruction word |
| gpr_val | input | 64 | Value of the source general register |
| cp0_usable | input | 1 | Control-register access enabled |
| vz_present | input | 1 | Virtualization feature present |
| exc_cpu | output | 1 | Coprocessor-unusable exception |
| exc_ri | output | 1 | Reserved-instruction exception |
| not_mine | output | 1 | Valid word is not this instruction |
| wr_en | output | 1 | A write commits at the next edge |
| wr_idx | output | 3 | Slot number being written |
| wr_data | output | 64 | Final value written to the slot |
| rd_idx | input | 3 | Read-port slot number |
| rd_data | output | 64 | Read-port slot contents |

## Verification
The assertions check on every cycle that:
- at most one of the four outcomes fires;
- no write happens without access enabled and the feature present;
- an idle strobe leaves the outputs quiet;
- entry-low writes carry zeros in bits 61:30;
- the read-only slot never changes;
- no bit outside a slot's guest mask ever changes.

Only the bench's scenarios can show the actual stored values: the bit remap, full 64-bit writes, that rs and sel together pick the slot, and that absent or unknown keys leave every slot as it was.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int XLEN = 64;
  localparam int KEYW = 8;   // {rs[4:0], sel[2:0]}

  localparam logic [5:0] OP_MAJOR = 6'b000000;
  localparam logic [1:0] OP_RSVD  = 2'b00;
  localparam logic [4:0] OP_MINOR = 5'b11011;
  localparam logic [5:0] OP_FUNC  = 6'b111100;

  typedef struct packed {
    logic            match;
    logic [4:0]      rs;
    logic [2:0]      sel;
  } gcr_dec_t;

  // default slot table, slot 7 first
  localparam logic [7:0][KEYW-1:0] DEF_KEY =
    {8'hB0, 8'h22, 8'h28, 8'h20, 8'h98, 8'h48, 8'h18, 8'h10};
  localparam logic [7:0] DEF_PRESENT = 8'b0111_1111;
  localparam logic [7:0] DEF_RO      = 8'b0000_0100;
  localparam logic [7:0] DEF_ELO     = 8'b0000_0011;
  localparam logic [7:0][XLEN-1:0] DEF_MASK =
    {{XLEN{1'b1}}, {XLEN{1'b1}}, {XLEN{1'b1}}, {XLEN{1'b1}},
     64'h0000_0000_0000_0FF8, {XLEN{1'b1}}, {XLEN{1'b1}}, {XLEN{1'b1}}};

  function automatic logic [XLEN-1:0] elo_shape(input logic [XLEN-1:0] src);
    return {src[31], src[30], 32'd0, src[29:0]};
  endfunction

  function automatic logic [XLEN-1:0] mask_merge(input logic [XLEN-1:0] old_v,
                                                 input logic [XLEN-1:0] new_v,
                                                 input logic [XLEN-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction
endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
(
  input  logic [31:0] instr,
  output gcr_dec_t    dec
);
  logic fields_ok;
  assign fields_ok = (instr[31:26] == OP_MAJOR) && (instr[15:14] == OP_RSVD) &&
                     (instr[10:6] == OP_MINOR) && (instr[5:0] == OP_FUNC);
  assign dec.match = fields_ok;
  assign dec.rs    = instr[20:16];
  assign dec.sel   = instr[13:11];
endmodule

// File: rtl/gcr_lookup.sv
module gcr_lookup
  import gcr_pkg::*;
#(
  parameter int NREG = 8,
  parameter int IW = (NREG > 1) ? $clog2(NREG) : 1,
  parameter logic [NREG-1:0][KEYW-1:0] SLOT_KEY = DEF_KEY
)(
  input  logic [KEYW-1:0] key,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  logic [NREG-1:0] slot_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign slot_hit[g] = (SLOT_KEY[g] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/gcr_regfile.sv
module gcr_regfile
  import gcr_pkg::*;
#(
  parameter int NREG = 8,
  parameter int IW = (NREG > 1) ? $clog2(NREG) : 1,
  parameter logic [NREG-1:0]           SLOT_RO   = DEF_RO,
  parameter logic [NREG-1:0][XLEN-1:0] SLOT_MASK = DEF_MASK
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   wi,
  input  logic [XLEN-1:0] wd,
  input  logic [IW-1:0]   ri_a,
  output logic [XLEN-1:0] rd_a,
  input  logic [IW-1:0]   ri_b,
  output logic [XLEN-1:0] rd_b
);
  logic [XLEN-1:0] q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else if (we) begin
      q[wi] <= wd;
    end
  end

  assign rd_a = q[ri_a];
  assign rd_b = q[ri_b];

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    // R8
    hidden_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((q[g] & ~SLOT_MASK[g]) == ($past(q[g]) & ~SLOT_MASK[g])));
    if (SLOT_RO[g]) begin : g_ro
      // R7
      ro_slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(q[g]));
    end
  end
endmodule

// File: rtl/gcr_write_unit.sv
module gcr_write_unit
  import gcr_pkg::*;
#(
  parameter int NREG = 8,
  parameter int IW = (NREG > 1) ? $clog2(NREG) : 1,
  parameter logic [NREG-1:0][KEYW-1:0] SLOT_KEY     = DEF_KEY,
  parameter logic [NREG-1:0]           SLOT_PRESENT = DEF_PRESENT,
  parameter logic [NREG-1:0]           SLOT_RO      = DEF_RO,
  parameter logic [NREG-1:0]           SLOT_ELO     = DEF_ELO,
  parameter logic [NREG-1:0][XLEN-1:0] SLOT_MASK    = DEF_MASK
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] gpr_val,
  input  logic            cp0_usable,
  input  logic            vz_present,
  output logic            exc_cpu,
  output logic            exc_ri,
  output logic            not_mine,
  output logic            wr_en,
  output logic [IW-1:0]   wr_idx,
  output logic [XLEN-1:0] wr_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_data
);
  gcr_dec_t        dec;
  logic            accepted, go, slot_hit, commit;
  logic [IW-1:0]   slot_idx;
  logic [XLEN-1:0] old_val, shaped, merged;

  gcr_decode u_dec (.instr(instr), .dec(dec));

  gcr_lookup #(.NREG(NREG), .IW(IW), .SLOT_KEY(SLOT_KEY)) u_lkp (
    .key({dec.rs, dec.sel}), .hit(slot_hit), .idx(slot_idx));

  assign accepted = in_valid && dec.match;
  assign not_mine = in_valid && !dec.match;
  assign exc_cpu  = accepted && !cp0_usable;
  assign exc_ri   = accepted && cp0_usable && !vz_present;
  assign go       = accepted && cp0_usable && vz_present;
  assign commit   = go && slot_hit && SLOT_PRESENT[slot_idx] && !SLOT_RO[slot_idx];

  assign shaped = SLOT_ELO[slot_idx] ? elo_shape(gpr_val) : gpr_val;
  assign merged = mask_merge(old_val, shaped, SLOT_MASK[slot_idx]);

  assign wr_en   = commit;
  assign wr_idx  = commit ? slot_idx : '0;
  assign wr_data = commit ? merged : '0;

  gcr_regfile #(.NREG(NREG), .IW(IW), .SLOT_RO(SLOT_RO), .SLOT_MASK(SLOT_MASK)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .wi(wr_idx), .wd(wr_data),
    .ri_a(rd_idx), .rd_a(rd_data), .ri_b(slot_idx), .rd_b(old_val));

  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_cpu, exc_ri, not_mine, wr_en}));
  // R2
  no_write_unusable_chk: assert property (@(posedge clk) disable iff (rst)
    !cp0_usable |-> (!wr_en && !exc_ri));
  // R3
  no_write_novz_chk: assert property (@(posedge clk) disable iff (rst)
    !vz_present |-> !wr_en);
  // R4
  elo_gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && SLOT_ELO[wr_idx]) |-> (wr_data[61:30] == 32'd0));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !(wr_en || exc_cpu || exc_ri || not_mine));
endmodule

// File: tb/gcr_write_unit_bench.sv
module gcr_write_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] gpr_val = '0;
  logic        cp0_usable = 1'b0, vz_present = 1'b0;
  logic        exc_cpu, exc_ri, not_mine, wr_en;
  logic [2:0]  wr_idx, rd_idx = '0;
  logic [63:0] wr_data, rd_data;
  int          n_chk = 0, n_bad = 0;
  logic        s_cpu, s_ri, s_nm, s_we;
  logic [2:0]  s_idx;
  logic [63:0] s_data;

  gcr_write_unit u_gcr_write_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .gpr_val(gpr_val),
    .cp0_usable(cp0_usable), .vz_present(vz_present), .exc_cpu(exc_cpu),
    .exc_ri(exc_ri), .not_mine(not_mine), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] word(input logic [4:0] rs, input logic [2:0] sel);
    return {6'b000000, 5'd7, rs, 2'b00, sel, 5'b11011, 6'b111100};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] d,
                       input logic cu, input logic vz, input logic v = 1'b1);
    @(negedge clk);
    instr = w; gpr_val = d; cp0_usable = cu; vz_present = vz; in_valid = v;
    #1;
    s_cpu = exc_cpu; s_ri = exc_ri; s_nm = not_mine; s_we = wr_en;
    s_idx = wr_idx; s_data = wr_data;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int slot, input logic [63:0] exp);
    rd_idx = 3'(slot);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic outs_chk(input string req, input logic c, input logic r,
                          input logic n, input logic w);
    chk(req, {60'd0, s_cpu, s_ri, s_nm, s_we}, {60'd0, c, r, n, w});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd_chk("R9 reset", i, 64'd0);
  endtask

  task automatic t_full;
    issue(word(5'd4, 3'd0), 64'hDEAD_BEEF_0123_4567, 1, 1);
    outs_chk("R10 outs", 0, 0, 0, 1);
    chk("R10 idx", {61'd0, s_idx}, 64'd4);
    chk("R5 wdata", s_data, 64'hDEAD_BEEF_0123_4567);
    rd_chk("R5 store", 4, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_sel;
    issue(word(5'd4, 3'd2), 64'h1111_2222_3333_4444, 1, 1);
    chk("R10 sel idx", {61'd0, s_idx}, 64'd6);
    rd_chk("R10 sel slot6", 6, 64'h1111_2222_3333_4444);
    rd_chk("R10 slot4 kept", 4, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_elo;
    issue(word(5'd2, 3'd0), 64'hFFFF_FFFF_C000_0001, 1, 1);
    rd_chk("R4 elo0", 0, 64'hC000_0000_0000_0001);
    issue(word(5'd3, 3'd0), 64'h0000_0000_8123_4567, 1, 1);
    chk("R4 elo1 wdata", s_data, 64'h8000_0000_0123_4567);
    rd_chk("R4 elo1", 1, 64'h8000_0000_0123_4567);
  endtask

  task automatic t_ro;
    issue(word(5'd9, 3'd0), 64'h5555_5555_5555_5555, 1, 1);
    outs_chk("R7 outs", 0, 0, 0, 0);
    rd_chk("R7 count", 2, 64'd0);
  endtask

  task automatic t_absent;
    issue(word(5'd22, 3'd0), 64'hAAAA_AAAA_AAAA_AAAA, 1, 1);
    outs_chk("R6 absent outs", 0, 0, 0, 0);
    rd_chk("R6 slot7", 7, 64'd0);
    issue(word(5'd30, 3'd5), 64'hAAAA_AAAA_AAAA_AAAA, 1, 1);
    outs_chk("R6 unknown outs", 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i); #1;
      if (i != 4 && i != 6 && i != 0 && i != 1) chk("R6 untouched", rd_data, 64'd0);
    end
  endtask

  task automatic t_shared;
    issue(word(5'd19, 3'd0), 64'hFFFF_FFFF_FFFF_FFFF, 1, 1);
    chk("R8 wdata", s_data, 64'h0000_0000_0000_0FF8);
    rd_chk("R8 masked", 3, 64'h0000_0000_0000_0FF8);
    issue(word(5'd19, 3'd0), 64'h0000_0000_0000_0A50, 1, 1);
    rd_chk("R8 rewrite", 3, 64'h0000_0000_0000_0A50);
  endtask

  task automatic t_exc;
    issue(word(5'd5, 3'd0), 64'h1234, 0, 0);
    outs_chk("R2 cu first", 1, 0, 0, 0);
    issue(word(5'd5, 3'd0), 64'h1234, 0, 1);
    outs_chk("R2 cu", 1, 0, 0, 0);
    issue(word(5'd5, 3'd0), 64'h1234, 1, 0);
    outs_chk("R3 ri", 0, 1, 0, 0);
    rd_chk("R3 no write", 5, 64'd0);
  endtask

  task automatic t_notmine;
    issue(word(5'd5, 3'd0) ^ 32'h0000_0040, 64'h77, 1, 1);
    outs_chk("R1 minor", 0, 0, 1, 0);
    issue(word(5'd5, 3'd0) | 32'h0000_4000, 64'h77, 0, 1);
    outs_chk("R1 rsvd", 0, 0, 1, 0);
    issue(word(5'd5, 3'd0) | 32'h0400_0000, 64'h77, 1, 1);
    outs_chk("R1 major", 0, 0, 1, 0);
    rd_chk("R1 no write", 5, 64'd0);
  endtask

  task automatic t_idle;
    issue(word(5'd5, 3'd0), 64'h99, 1, 1, 1'b0);
    outs_chk("R9 idle", 0, 0, 0, 0);
    rd_chk("R9 idle store", 5, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_full();
    t_sel();
    t_elo();
    t_ro();
    t_absent();
    t_shared();
    t_exc();
    t_notmine();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule